// File: doc/BRIEF.md
# Universal Shift/Storage Register with Shared Parallel Bus

This block is a parameterised register, eight bits wide by default. On each rising clock edge it can keep its contents, move them one place toward the most significant bit, move them one place toward the least significant bit, or capture a parallel word. A two-bit select chooses the action.

The parallel word arrives on the same bus that carries the register contents out. The block exposes that bus as three signals: a data input, a data output and a drive enable. An integrator wraps these three signals in a three-state pad or in a bus resolver. The bus is driven only when two active-low enables are both asserted. It is never driven while the load action is selected, so an external source can present data with no contention.

Each shift direction has its own serial input. Two always-driven outputs carry the lowest and highest register bits, so several registers can be chained into a wider shifter. An asynchronous active-low clear overrides every other input.

Top module: `univ_shift_bank`

## Requirements
- R1: While `rst_n` is low, every register bit is zero. The clear takes effect without waiting for a clock edge.
- R2: With `mode_sel` = 2'b00, the register keeps its value across a rising clock edge.
- R3: With `mode_sel` = 2'b01, a rising edge moves bit n to bit n+1, and bit 0 takes `ser_in_lo`.
- R4: With `mode_sel` = 2'b10, a rising edge moves bit n to bit n-1, and the top bit takes `ser_in_hi`.
- R5: With `mode_sel` = 2'b11, a rising edge copies `bus_in` into the register.
- R6: `bus_oe` is high exactly when `oe_a_n` and `oe_b_n` are both low and `mode_sel` is not 2'b11.
- R7: Whenever `bus_oe` is high, `bus_out` equals the register contents. In the default configuration (`IDLE_ZERO` = 1), `bus_out` is all zeros whenever `bus_oe` is low.
- R8: `tail_lo` always shows register bit 0 and `tail_hi` always shows the top bit. Neither depends on the output enables or on the mode.
- R9: A clear that is held over a rising edge in load mode leaves the register at zero.
- R10: Two instances chained (the low instance's `tail_hi` to the high instance's `ser_in_lo`, and the high instance's `tail_lo` to the low instance's `ser_in_hi`) behave as one register of twice the width in both shift directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | Action select: 00 keep, 01 toward MSB, 10 toward LSB, 11 parallel capture |
| ser_in_lo | input | 1 | Serial bit entering bit 0 when shifting toward the MSB |
| ser_in_hi | input | 1 | Serial bit entering the top bit when shifting toward the LSB |
| oe_a_n | input | 1 | Bus drive enable A, active low |
| oe_b_n | input | 1 | Bus drive enable B, active low |
| bus_in | input | WIDTH | Value seen on the shared bus |
| bus_out | output | WIDTH | Value the block drives onto the shared bus |
| bus_oe | output | 1 | High when the block drives the shared bus |
| tail_lo | output | 1 | Register bit 0, always driven |
| tail_hi | output | 1 | Register top bit, always driven |

## Verification
Every one of the 256 byte values is captured, read back over the bus, and then shifted once in each direction. The serial bit for each shift comes from a different position of the value, so a swapped direction or a swapped serial input produces a different byte. All sixteen combinations of the two enables and the two selects are applied to separate bus-enable faults from mode-decode faults. A chained pair is shifted with an irregular serial pattern in both directions, which exposes any break at the seam between the two instances. Clears are applied between clock edges and across a load edge, to tell an asynchronous clear with top priority from a synchronous one or one with lower priority.

// File: rtl/shr_pkg.sv
package shr_pkg;

   typedef enum logic [1:0] {
      SHR_KEEP     = 2'b00,
      SHR_TO_MSB   = 2'b01,
      SHR_TO_LSB   = 2'b10,
      SHR_CAPTURE  = 2'b11
   } shr_mode_e;

endpackage

// File: rtl/shr_mode_decode.sv
module shr_mode_decode
   import shr_pkg::*;
(
   input  logic [1:0] sel,
   input  logic       en_a_n,
   input  logic       en_b_n,
   output shr_mode_e  mode,
   output logic       drive_ok
);

   always_comb begin
      mode = shr_mode_e'(sel);
   end

   // the capture action always releases the bus so that outside data can be sampled
   always_comb begin
      drive_ok = ~en_a_n & ~en_b_n & (mode != SHR_CAPTURE);
   end

endmodule

// File: rtl/shr_next_value.sv
module shr_next_value
   import shr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  shr_mode_e          mode,
   input  logic [WIDTH-1:0]   cur,
   input  logic               fill_lo,
   input  logic               fill_hi,
   input  logic [WIDTH-1:0]   par_in,
   output logic [WIDTH-1:0]   nxt
);

   localparam int TOP = WIDTH - 1;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic from_below;
      logic from_above;

      if (i == 0) begin : g_lo_edge
         assign from_below = fill_lo;
      end else begin : g_lo_inner
         assign from_below = cur[i-1];
      end

      if (i == TOP) begin : g_hi_edge
         assign from_above = fill_hi;
      end else begin : g_hi_inner
         assign from_above = cur[i+1];
      end

      always_comb begin
         unique case (mode)
            SHR_KEEP:    nxt[i] = cur[i];
            SHR_TO_MSB:  nxt[i] = from_below;
            SHR_TO_LSB:  nxt[i] = from_above;
            SHR_CAPTURE: nxt[i] = par_in[i];
            default:     nxt[i] = cur[i];
         endcase
      end
   end

endmodule

// File: rtl/shr_store.sv
module shr_store #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q <= d;
      end
   end

endmodule

// File: rtl/shr_bus_drive.sv
module shr_bus_drive #(
   parameter int WIDTH     = 8,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic [WIDTH-1:0] q,
   input  logic             drive_ok,
   output logic [WIDTH-1:0] bus_out,
   output logic             bus_oe
);

   assign bus_oe = drive_ok;

   if (IDLE_ZERO) begin : g_gated
      // quiet data lines while released: less toggling into the pad ring
      assign bus_out = drive_ok ? q : '0;
   end else begin : g_open
      assign bus_out = q;
   end

endmodule

// File: rtl/univ_shift_bank.sv
module univ_shift_bank
   import shr_pkg::*;
#(
   parameter int WIDTH     = 8,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_sel,
   input  logic             ser_in_lo,
   input  logic             ser_in_hi,
   input  logic             oe_a_n,
   input  logic             oe_b_n,
   input  logic [WIDTH-1:0] bus_in,
   output logic [WIDTH-1:0] bus_out,
   output logic             bus_oe,
   output logic             tail_lo,
   output logic             tail_hi
);

   localparam int TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("univ_shift_bank: WIDTH must be at least 2");
   end

   shr_mode_e        mode;
   logic             drive_ok;
   logic [WIDTH-1:0] nxt;
   logic [WIDTH-1:0] q;

   shr_mode_decode u_decode (
      .sel      (mode_sel),
      .en_a_n   (oe_a_n),
      .en_b_n   (oe_b_n),
      .mode     (mode),
      .drive_ok (drive_ok)
   );

   shr_next_value #(.WIDTH(WIDTH)) u_next (
      .mode    (mode),
      .cur     (q),
      .fill_lo (ser_in_lo),
      .fill_hi (ser_in_hi),
      .par_in  (bus_in),
      .nxt     (nxt)
   );

   shr_store #(.WIDTH(WIDTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nxt),
      .q     (q)
   );

   shr_bus_drive #(.WIDTH(WIDTH), .IDLE_ZERO(IDLE_ZERO)) u_drive (
      .q        (q),
      .drive_ok (drive_ok),
      .bus_out  (bus_out),
      .bus_oe   (bus_oe)
   );

   assign tail_lo = q[0];
   assign tail_hi = q[TOP];

endmodule

// File: rtl/shr_checker.sv
module shr_checker #(
   parameter int WIDTH     = 8,
   parameter bit IDLE_ZERO = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode_sel,
   input logic             ser_in_lo,
   input logic             ser_in_hi,
   input logic             oe_a_n,
   input logic             oe_b_n,
   input logic [WIDTH-1:0] bus_in,
   input logic [WIDTH-1:0] bus_out,
   input logic             bus_oe,
   input logic             tail_lo,
   input logic             tail_hi,
   input logic [WIDTH-1:0] q
);

   // R1
   rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (q == '0));

   // R2
   keep_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'b00) |=> (q == $past(q)));

   // R3
   to_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'b01) |=> (q == {$past(q[WIDTH-2:0]), $past(ser_in_lo)}));

   // R4
   to_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'b10) |=> (q == {$past(ser_in_hi), $past(q[WIDTH-1:1])}));

   // R5
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'b11) |=> (q == $past(bus_in)));

   // R6
   capture_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'b11) |-> !bus_oe);

   // R6
   enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_a_n || oe_b_n) |-> !bus_oe);

   // R7
   drive_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> (bus_out == q));

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (IDLE_ZERO && !bus_oe) |-> (bus_out == '0));

   // R8
   tail_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_lo == q[0]) && (tail_hi == q[WIDTH-1]));

endmodule

bind univ_shift_bank shr_checker #(.WIDTH(WIDTH), .IDLE_ZERO(IDLE_ZERO)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_sel  (mode_sel),
   .ser_in_lo (ser_in_lo),
   .ser_in_hi (ser_in_hi),
   .oe_a_n    (oe_a_n),
   .oe_b_n    (oe_b_n),
   .bus_in    (bus_in),
   .bus_out   (bus_out),
   .bus_oe    (bus_oe),
   .tail_lo   (tail_lo),
   .tail_hi   (tail_hi),
   .q         (q)
);

// File: tb/univ_shift_bank_bench.sv
module univ_shift_bank_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic [1:0] mode_sel = 2'b00;
   logic       ser_lo = 1'b0;
   logic       ser_hi = 1'b0;
   logic       oe_a_n = 1'b0;
   logic       oe_b_n = 1'b0;
   logic       chain = 1'b0;
   logic [7:0] ext_a = '0;
   logic [7:0] ext_b = '0;
   logic       ext_en;

   logic [7:0] a_bus_in, a_bus_out, b_bus_in, b_bus_out;
   logic       a_oe, b_oe, a_tlo, a_thi, b_tlo, b_thi, a_shi;

   int checks = 0;
   int fails  = 0;
   logic [7:0]  m;
   logic [15:0] m16;

   always #10 clk = ~clk;

   assign ext_en   = (mode_sel == 2'b11);
   assign a_bus_in = a_oe ? a_bus_out : ext_a;
   assign b_bus_in = b_oe ? b_bus_out : ext_b;
   assign a_shi    = chain ? b_tlo : ser_hi;

   univ_shift_bank u_univ_shift_bank (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
      .ser_in_lo(ser_lo), .ser_in_hi(a_shi),
      .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
      .bus_in(a_bus_in), .bus_out(a_bus_out), .bus_oe(a_oe),
      .tail_lo(a_tlo), .tail_hi(a_thi)
   );

   univ_shift_bank u_upper (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
      .ser_in_lo(a_thi), .ser_in_hi(ser_hi),
      .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
      .bus_in(b_bus_in), .bus_out(b_bus_out), .bus_oe(b_oe),
      .tail_lo(b_tlo), .tail_hi(b_thi)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] step8(logic [7:0] v, logic [1:0] md, logic sl, logic sh, logic [7:0] d);
      case (md)
         2'b01:   return {v[6:0], sl};
         2'b10:   return {sh, v[7:1]};
         2'b11:   return d;
         default: return v;
      endcase
   endfunction

   // drive at the falling edge, check the enable decode, clock, check state
   task automatic cyc(input logic [1:0] md, input logic sl, input logic sh,
                      input logic [7:0] d, input logic an, input logic bn);
      @(negedge clk);
      mode_sel = md; ser_lo = sl; ser_hi = sh; ext_a = d; oe_a_n = an; oe_b_n = bn;
      #2;
      chk("R6 enable decode", {15'd0, a_oe}, {15'd0, (!an && !bn && md != 2'b11)});
      if (a_oe && ext_en) chk("R6 contention", 16'd1, 16'd0);
      m = step8(m, md, sl, sh, d);
      @(posedge clk);
      #5;
      chk("R2-R5 register step", {8'd0, a_oe ? a_bus_out : m}, {8'd0, m});
      chk("R8 tails", {14'd0, a_thi, a_tlo}, {14'd0, m[7], m[0]});
      chk("R7 bus data", {8'd0, a_bus_out}, a_oe ? {8'd0, m} : 16'd0);
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      m = '0;
      #3 rst_n = 1'b0;
      @(posedge clk); #5;
      // R1 reset state
      chk("R1 reset state", {a_bus_out, 7'd0, a_oe}, {8'd0, 8'd1});
      chk("R1 reset tails", {14'd0, a_thi, a_tlo}, 16'd0);
      @(negedge clk) rst_n = 1'b1;

      for (int v = 0; v < 256; v++) begin
         logic [7:0] b;
         b = v[7:0];
         cyc(2'b11, 1'b0, 1'b0, b, 1'b0, 1'b0);          // R5 capture
         chk("R5 capture value", {8'd0, m}, {8'd0, b});
         cyc(2'b00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);      // R2 keep, read over bus
         chk("R7 readback", {8'd0, a_bus_out}, {8'd0, b});
         cyc(2'b01, b[3], ~b[3], 8'h00, 1'b0, 1'b0);     // R3
         cyc(2'b10, ~b[5], b[5], 8'h00, 1'b0, 1'b0);     // R4
         cyc(2'b00, 1'b1, 1'b1, 8'hff, b[1], b[2]);      // R8 tails with bus released
      end

      // R6 every enable and select combination
      for (int e = 0; e < 16; e++) begin
         cyc(e[1:0], e[0], e[1], 8'(e * 37 + 5), e[2], e[3]);
      end

      // R1 asynchronous clear between edges
      cyc(2'b11, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0);
      cyc(2'b00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
      @(negedge clk); #3 rst_n = 1'b0; #1;
      chk("R1 async clear", {8'd0, a_bus_out}, 16'd0);
      chk("R1 async tails", {14'd0, a_thi, a_tlo}, 16'd0);
      // R9 clear held over a capture edge
      mode_sel = 2'b11; ext_a = 8'hFF;
      @(posedge clk); #5;
      mode_sel = 2'b00;
      #1;
      chk("R9 clear beats capture", {8'd0, a_bus_out}, 16'd0);
      @(negedge clk) rst_n = 1'b1;
      m = '0;

      // R10 chained pair
      chain = 1'b1;
      @(negedge clk);
      mode_sel = 2'b11; ext_a = 8'h81; ext_b = 8'h3C; oe_a_n = 1'b0; oe_b_n = 1'b0;
      @(posedge clk); #5;
      m16 = 16'h3C81;
      for (int k = 0; k < 40; k++) begin
         logic [1:0] md;
         logic       s;
         md = (k < 20) ? 2'b01 : 2'b10;
         s  = ((k * 7) % 5) < 2;
         @(negedge clk);
         mode_sel = md; ser_lo = s; ser_hi = ~s;
         m16 = (md == 2'b01) ? {m16[14:0], s} : {~s, m16[15:1]};
         @(posedge clk); #5;
         chk("R10 cascade", {b_bus_out, a_bus_out}, m16);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule